// File: doc/BRIEF.md
# I2C Burst Receive Engine

This block is the receive sequencer of an I2C master. Software writes a single configuration byte that holds a burst length and a flag choosing whether the final byte of the burst is answered with NAK. The engine then collects that many bytes from the addressed slave, one bit per rising SCL edge, and answers each byte with ACK or NAK during the ninth clock. Each completed byte goes into a 64-entry receive FIFO. Software drains the FIFO through a pop strobe. When the last acknowledge clock of the burst ends, a sticky completion flag is raised. That flag can be routed to an interrupt line.

SCL itself is produced by a separate clock generator. The engine raises `busy_o` to ask that generator to run, and it watches the synchronised `scl_i` and `sda_i` levels. It pulls SDA low only during acknowledge clocks. Setting up SDA changes only on SCL falling edges. A long read is built by chaining bursts: every burst except the last is written with the flag clear, so all of its bytes are ACKed and the slave keeps sending.

The controller runs through four states:
- `RX_IDLE` to `RX_SHIFT` when a non-zero count is accepted.
- `RX_SHIFT` to `RX_ACK_SETUP` on the rising SCL edge that carries the eighth data bit.
- `RX_ACK_SETUP` to `RX_ACK_HOLD` on the next SCL falling edge.
- `RX_ACK_HOLD` back to `RX_SHIFT` on the falling edge that ends the ninth clock, or to `RX_IDLE` on that edge when it closes the final byte.

Top module: `i2c_burst_rx`

## Requirements
- R1: After reset the engine is idle: `busy_o`=0, `rd_done_o`=0, `irq_o`=0, `sda_pull_o`=0 and `rx_empty_o`=1.
- R2: `cfg_wdata` bits [6:0] hold the byte count and bit 7 holds the NAK-last flag. A write made while idle with a non-zero count sets `busy_o` on the following clock cycle and clears `rd_done_o`.
- R3: Each byte is assembled most significant bit first, with SDA sampled at SCL rising edges. Bytes enter the FIFO in arrival order, across consecutive bursts.
- R4: For every byte except a flagged final byte, `sda_pull_o` is 1 from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth clock.
- R5: When the NAK-last flag is 1, `sda_pull_o` stays 0 throughout the ninth clock of the burst's final byte.
- R6: After the ninth clock of the last requested byte ends, `busy_o` returns to 0 and `rd_done_o` becomes 1.
- R7: A count of 0 sets `rd_done_o` on the next cycle, leaves `busy_o` at 0 and requests no SCL activity.
- R8: A configuration write while `busy_o`=1 is ignored. The running burst keeps its count and its NAK-last flag.
- R9: `rd_data` shows the oldest unread byte. A `rd_pop` pulse removes it, and `rx_empty_o` is 1 exactly when no byte is held.
- R10: `irq_o` equals `rd_done_o` AND `irq_en`. `rd_done_o` is cleared by a `done_clr` pulse or by an accepted new burst.
- R11: A count field above 64 is treated as 64.
- R12: The FIFO holds 64 bytes, so a full 64-byte burst into an empty FIFO loses no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the burst configuration |
| cfg_wdata | input | 8 | Count in [6:0], NAK-last flag in [7] |
| done_clr | input | 1 | Clears the completion flag |
| irq_en | input | 1 | Routes completion to `irq_o` |
| rd_pop | input | 1 | Removes the head byte of the FIFO |
| rd_data | output | 8 | Head byte of the FIFO |
| rx_empty_o | output | 1 | FIFO holds no byte |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_pull_o | output | 1 | 1 drives SDA low (ACK) |
| busy_o | output | 1 | Burst active; requests SCL from the clock generator |
| rd_done_o | output | 1 | Sticky read-complete flag |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions take for granted that software never asks for more bytes than the FIFO has free space. They also take for granted that SCL edges are spaced several core clocks apart, so that each edge passes the synchroniser as its own event. The stimulus respects both. Every SCL half period lasts six core cycles. The FIFO is drained before any burst that could fill it, including the clipped 64-byte burst. The slave model changes SDA only while SCL is low.

// File: rtl/i2c_burst_rx_pkg.sv
package i2c_burst_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_ACK_SETUP,
        RX_ACK_HOLD
    } rx_state_e;
endpackage

// File: rtl/rxb_sync_edge.sv
module rxb_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s
);
    logic [2:0] scl_q;
    logic [1:0] sda_q;

    // bus idles high, so the synchronisers reset to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[0], sda_i};
        end
    end

    assign scl_rise = scl_q[1] & ~scl_q[2];
    assign scl_fall = ~scl_q[1] & scl_q[2];
    assign sda_s    = sda_q[1];
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [AW:0]   level_q;
    logic          push_ok, pop_ok;

    assign empty   = (level_q == '0);
    assign full    = (level_q == (AW+1)'(DEPTH));
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign head    = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_q <= '0;
        end else begin
            if (push_ok) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            level_q <= level_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end

    // R12: the engine never delivers a byte into a full FIFO
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R9: an accepted pop lowers the level by one unless a push coincides
    p_pop_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (level_q == $past(level_q) - 1'b1));
endmodule

// File: rtl/i2c_burst_rx.sv
module i2c_burst_rx
    import i2c_burst_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    input  logic              done_clr,
    input  logic              irq_en,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_empty_o,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              busy_o,
    output logic              rd_done_o,
    output logic              irq_o
);
    localparam int CNT_W   = $clog2(FIFO_DEPTH) + 1;
    localparam int NAK_BIT = CNT_W;
    localparam int BIT_W   = $clog2(DATA_W);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   remain_q, req_cnt, clip_cnt;
    logic               nak_q, done_q;
    logic [DATA_W-1:0]  shreg_q, byte_in;
    logic [BIT_W-1:0]   bitcnt_q;
    logic               scl_rise, scl_fall, sda_s;
    logic               accept, last_byte, push, fifo_full;

    rxb_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .sda_s   (sda_s)
    );

    assign req_cnt   = cfg_wdata[CNT_W-1:0];
    assign clip_cnt  = (req_cnt > CNT_W'(FIFO_DEPTH)) ? CNT_W'(FIFO_DEPTH) : req_cnt;
    assign accept    = cfg_wr && (state_q == RX_IDLE);
    assign last_byte = (remain_q == CNT_W'(1));
    assign byte_in   = {shreg_q[DATA_W-2:0], sda_s};
    assign push      = (state_q == RX_SHIFT) && scl_rise && (bitcnt_q == BIT_W'(DATA_W-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:      if (accept && clip_cnt != '0) state_d = RX_SHIFT;
            RX_SHIFT:     if (push) state_d = RX_ACK_SETUP;
            RX_ACK_SETUP: if (scl_fall) state_d = RX_ACK_HOLD;
            RX_ACK_HOLD:  if (scl_fall) state_d = last_byte ? RX_IDLE : RX_SHIFT;
            default:      state_d = RX_IDLE;
        endcase
    end

    // burst datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            nak_q    <= 1'b0;
            done_q   <= 1'b0;
            shreg_q  <= '0;
            bitcnt_q <= '0;
        end else begin
            if (done_clr) done_q <= 1'b0;
            if (accept) begin
                remain_q <= clip_cnt;
                nak_q    <= cfg_wdata[NAK_BIT];
                bitcnt_q <= '0;
                done_q   <= (clip_cnt == '0);
            end
            if (state_q == RX_SHIFT && scl_rise) begin
                shreg_q  <= byte_in;
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (state_q == RX_ACK_HOLD && scl_fall) begin
                remain_q <= remain_q - 1'b1;
                if (last_byte) done_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != RX_IDLE);
        sda_pull_o = (state_q == RX_ACK_HOLD) && !(nak_q && last_byte);
        rd_done_o  = done_q;
        irq_o      = done_q & irq_en;
    end

    rxb_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(byte_in),
        .pop      (rd_pop),
        .head     (rd_data),
        .empty    (rx_empty_o),
        .full     (fifo_full)
    );

    // R4: the acknowledge drive only turns on at an SCL falling edge
    p_pull_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));

    // R4: it only turns off at an SCL falling edge
    p_release_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> $past(scl_fall));

    // R7: a zero count completes without a burst
    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !busy_o && cfg_wdata[CNT_W-1:0] == '0) |=> (rd_done_o && !busy_o));

    // R2: a non-zero count starts a burst and clears completion
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !busy_o && cfg_wdata[CNT_W-1:0] != '0) |=> (busy_o && !rd_done_o));

    // R6: completion is never shown while a burst runs
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |-> !busy_o);

    // R8: a write during a burst leaves the NAK choice untouched
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && busy_o) |=> $stable(nak_q));

    // R12: storage never fills while a byte is still due
    p_room_left_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_SHIFT) |-> !fifo_full);
endmodule

// File: tb/i2c_burst_rx_tb_top.sv
module i2c_burst_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       done_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rx_empty_o, sda_pull_o, busy_o, rd_done_o, irq_o;
    logic       scl = 1'b1;
    logic       slave_low = 1'b0;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    byte unsigned exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = ~(slave_low | sda_pull_o);

    i2c_burst_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .done_clr  (done_clr),
        .irq_en    (irq_en),
        .rd_pop    (rd_pop),
        .rd_data   (rd_data),
        .rx_empty_o(rx_empty_o),
        .scl_i     (scl),
        .sda_i     (sda_bus),
        .sda_pull_o(sda_pull_o),
        .busy_o    (busy_o),
        .rd_done_o (rd_done_o),
        .irq_o     (irq_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    // slave sends one byte MSB first, then the ninth clock is checked for ACK/NAK
    task automatic bus_byte(input byte unsigned b, input bit exp_pull);
        for (int i = 7; i >= 0; i--) begin
            slave_low = ~b[i];
            half_wait();
            scl = 1'b1;
            half_wait();
            scl = 1'b0;
        end
        slave_low = 1'b0;
        half_wait();
        check(sda_pull_o == exp_pull, exp_pull ? "R4 ack setup" : "R5 nak setup",
              sda_pull_o, exp_pull);
        scl = 1'b1;
        half_wait();
        check(sda_pull_o == exp_pull, exp_pull ? "R4 ack high" : "R5 nak high",
              sda_pull_o, exp_pull);
        scl = 1'b0;
    endtask

    // driver: starts a burst, plays the bus, queues the expected bytes
    task automatic run_burst(input logic [6:0] cnt, input bit nak, input int nbytes,
                             input int seed, input int inject_at);
        cfg_write({nak, cnt});
        check(busy_o == 1'b1, "R2 busy after write", busy_o, 1);
        check(rd_done_o == 1'b0, "R2 done cleared", rd_done_o, 0);
        scl = 1'b0;
        half_wait();
        for (int k = 0; k < nbytes; k++) begin
            byte unsigned b;
            b = 8'(k * 37 + seed);
            if (k == inject_at) cfg_write(8'h0A);
            exp_q.push_back(b);
            bus_byte(b, !(nak && k == nbytes - 1));
        end
        half_wait();
        check(busy_o == 1'b0, "R6 busy falls", busy_o, 0);
        check(rd_done_o == 1'b1, "R6 done set", rd_done_o, 1);
        scl = 1'b1;
        half_wait();
    endtask

    // monitor: pops every held byte and compares it against the scoreboard
    task automatic drain(input string req);
        while (!rx_empty_o) begin
            int unsigned e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hFFFF;
            check(rd_data == e[7:0], req, rd_data, e);
            @(negedge clk);
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
        check(exp_q.size() == 0, "R9 all bytes delivered", exp_q.size(), 0);
        check(rx_empty_o == 1'b1, "R9 empty after drain", rx_empty_o, 1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 0, "R1 busy", busy_o, 0);
        check(rd_done_o == 0, "R1 done", rd_done_o, 0);
        check(irq_o == 0, "R1 irq", irq_o, 0);
        check(sda_pull_o == 0, "R1 pull", sda_pull_o, 0);
        check(rx_empty_o == 1, "R1 empty", rx_empty_o, 1);

        // R3/R4/R5: three bytes, last NAKed
        run_burst(7'd3, 1'b1, 3, 8'hA5, -1);
        check(rx_empty_o == 0, "R9 not empty", rx_empty_o, 0);
        // R10 interrupt routing and clear
        check(irq_o == 0, "R10 irq masked", irq_o, 0);
        @(negedge clk); irq_en = 1'b1;
        @(negedge clk);
        check(irq_o == 1, "R10 irq enabled", irq_o, 1);
        pulse_clr();
        check(rd_done_o == 0, "R10 done cleared", rd_done_o, 0);
        check(irq_o == 0, "R10 irq cleared", irq_o, 0);
        drain("R3 byte order burst one");

        // R3/R4: chained read, first burst all ACKed
        run_burst(7'd2, 1'b0, 2, 8'h3C, -1);
        run_burst(7'd2, 1'b1, 2, 8'hF0, -1);
        drain("R3 byte order chained");

        // R7: zero count
        pulse_clr();
        cfg_write(8'h80);
        check(rd_done_o == 1, "R7 done at once", rd_done_o, 1);
        check(busy_o == 0, "R7 no burst", busy_o, 0);
        half_wait();
        check(busy_o == 0, "R7 still idle", busy_o, 0);
        check(rx_empty_o == 1, "R7 nothing stored", rx_empty_o, 1);
        pulse_clr();

        // R8: write during burst is ignored (count and NAK flag kept)
        run_burst(7'd3, 1'b1, 3, 8'h5A, 1);
        drain("R8 bytes of guarded burst");

        // R11/R12: count 127 is clipped to a full 64-byte burst
        run_burst(7'h7F, 1'b1, 64, 8'h11, -1);
        drain("R11 R12 clipped burst data");

        irq_en = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule